// File: doc/BRIEF.md
# Delay Ratio Calculator

This block converts a pair of measured counts into a delay-per-element figure in fixed-point tenths. A request carries a reference-clock period, a reference count, a delay-line count and a denominator constant, all unsigned 16 bits. The block forms the product P = reference count × reference-clock period and the divisor D = delay-line count × denominator. Both products are 32 bits wide.

The result is built in two parts so that no intermediate wider than the divider is needed. The first part is five times the integer quotient of P by D. The second part is the remainder of that division, scaled and rounded down separately. One restoring divider does both divisions in sequence. A zero delay-line count or a zero denominator skips the division, gives a zero result and raises a fault flag.

Callers typically issue two requests, one with denominator 88 for the coarse element and one with 264 for the fine element. A request is accepted when `start` is high on a clock edge while the block is idle. `done` pulses once when the result is ready.

Top module: `dly_ratio_calc`

## Requirements
- R1: For a nonzero divisor D, the quotient part of the result is 5 × floor(P / D), where P = ref_cnt × ref_period and D = line_cnt × denom, both exact 32-bit products.
- R2: The remainder part is floor(10 × (P mod D) / (2 × D)) computed exactly, so it is between 0 and 4 even when 10 × (P mod D) exceeds 32 bits.
- R3: `result` is the sum of the quotient part and the remainder part taken modulo 2^32.
- R4: When line_cnt or denom is zero at the accepting edge, `done` rises after that same edge with `result` = 0 and `fault` = 1.
- R5: Any computed result has `fault` = 0, including a zero product P.
- R6: For a nonzero divisor, `done` is high for exactly one cycle, after the 70th clock edge following the accepting edge (2 × (2 × 16 + 3) divider steps).
- R7: `start` is ignored while a computation is in progress. The timing and value of the pending result do not change.
- R8: `result` and `fault` hold their values between `done` pulses.
- R9: After reset, `done`, `result` and `fault` are all 0.
- R10: Any 16-bit denominator works, including the coarse value 88 and the fine value 264.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request; accepted only while idle |
| ref_period | input | 16 | Reference-clock period |
| line_cnt | input | 16 | Delay-line count |
| ref_cnt | input | 16 | Reference count |
| denom | input | 16 | Denominator constant |
| done | output | 1 | One-cycle result strobe |
| result | output | 32 | Delay value in tenths |
| fault | output | 1 | Zero count or zero denominator |

## Verification
Two corners are hard to reach with plain random counts. The first is a remainder part of 3 or 4 combined with a remainder so large that ten times it passes 32 bits. The second is a quotient large enough that five times it wraps. Directed requests build both of these by choosing D close to P and D equal to one. A second stimulus pattern raises `start` with different operands in the middle of a division, and a third holds `start` high across many results. Together they show that requests arriving while busy leave both the latency and the value unchanged.

// File: rtl/dly_ratio_calc.sv
module dly_ratio_calc #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   ref_period,
  input  logic [W-1:0]   line_cnt,
  input  logic [W-1:0]   ref_cnt,
  input  logic [W-1:0]   denom,
  output logic           done,
  output logic [2*W-1:0] result,
  output logic           fault
);
  localparam int PW = 2 * W;
  localparam int NW = PW + 3;
  localparam int CW = $clog2(NW + 1);
  localparam logic [CW-1:0] LAST = CW'(NW - 1);

  typedef enum logic [1:0] {S_IDLE, S_QUO, S_REM} st_t;
  st_t st;

  logic [PW-1:0] divisor, rem, qterm;
  logic [NW-1:0] quo;
  logic [CW-1:0] step;

  wire [PW:0]    trial  = {rem, quo[NW-1]} - {1'b0, divisor};
  wire           take   = !trial[PW];
  wire [PW-1:0]  rem_nx = take ? trial[PW-1:0] : {rem[PW-2:0], quo[NW-1]};
  wire [NW-1:0]  quo_nx = {quo[NW-2:0], take};
  wire           last   = (step == LAST);
  wire           zero_in = (line_cnt == '0) || (denom == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      done    <= 1'b0;
      result  <= '0;
      fault   <= 1'b0;
      divisor <= '0;
      rem     <= '0;
      quo     <= '0;
      qterm   <= '0;
      step    <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            if (zero_in) begin
              done   <= 1'b1;
              result <= '0;
              fault  <= 1'b1;
            end else begin
              divisor <= PW'(line_cnt) * PW'(denom);
              quo     <= NW'(PW'(ref_cnt) * PW'(ref_period));
              rem     <= '0;
              step    <= '0;
              st      <= S_QUO;
            end
          end
        end
        S_QUO: begin
          rem  <= rem_nx;
          quo  <= quo_nx;
          step <= step + CW'(1);
          if (last) begin
            qterm <= quo_nx[PW-1:0];
            quo   <= {3'b000, rem_nx} + {1'b0, rem_nx, 2'b00};
            rem   <= '0;
            step  <= '0;
            st    <= S_REM;
          end
        end
        S_REM: begin
          rem  <= rem_nx;
          quo  <= quo_nx;
          step <= step + CW'(1);
          if (last) begin
            result <= qterm * PW'(5) + quo_nx[PW-1:0];
            fault  <= 1'b0;
            done   <= 1'b1;
            step   <= '0;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dly_ratio_calc_chk.sv
module dly_ratio_calc_chk #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [W-1:0]   line_cnt,
  input logic [W-1:0]   denom,
  input logic           done,
  input logic [2*W-1:0] result,
  input logic           fault,
  input logic           busy
);
  localparam int LAT = 2 * (2 * W + 3);
  logic [15:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat <= '0;
    else if (!busy && start) lat <= '0;
    else if (busy) lat <= lat + 16'd1;
  end

  // R4: a zero operand gives an immediate zero result with the fault flag
  a_r4_zero_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (line_cnt == '0 || denom == '0)) |=> (done && fault && result == '0));

  // R6: a computed result appears after the fixed number of steps
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (lat == 16'(LAT)));

  // R7: a start while busy never yields an early fault strobe
  a_r7_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !(done && fault));

  // R8: outputs hold between strobes
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(fault)));
endmodule

bind dly_ratio_calc dly_ratio_calc_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .line_cnt(line_cnt), .denom(denom),
  .done(done), .result(result), .fault(fault), .busy(|st)
);

// File: tb/dly_ratio_calc_bench.sv
`timescale 1ns/1ps
module dly_ratio_calc_bench;
  localparam int LAT = 70;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] ref_period = '0, line_cnt = '0, ref_cnt = '0, denom = '0;
  logic done, fault;
  logic [31:0] result;

  int tests = 0, fails = 0;
  string tag = "R9";

  always #10 clk = ~clk;

  dly_ratio_calc u_dly_ratio_calc (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_period(ref_period),
    .line_cnt(line_cnt), .ref_cnt(ref_cnt), .denom(denom),
    .done(done), .result(result), .fault(fault)
  );

  function automatic logic [31:0] calc(input logic [15:0] per, ln, rc, dn);
    longint p, d, q, r;
    p = longint'(rc) * longint'(per);
    d = longint'(ln) * longint'(dn);
    q = p / d;
    r = p % d;
    return 32'(5 * q + (10 * r) / (2 * d));
  endfunction

  int left = 0;
  logic exp_done = 1'b0, exp_fault = 1'b0;
  logic [31:0] exp_res = '0, pend_res = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      left = 0; exp_done = 0; exp_res = 0; exp_fault = 0;
    end else begin
      exp_done = 0;
      if (left > 0) begin
        left--;
        if (left == 0) begin exp_done = 1; exp_res = pend_res; exp_fault = 0; end
      end else if (start) begin
        if (line_cnt == 0 || denom == 0) begin
          exp_done = 1; exp_res = 0; exp_fault = 1;
        end else begin
          pend_res = calc(ref_period, line_cnt, ref_cnt, denom);
          left = LAT;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      tests++;
      if (done !== exp_done) begin
        fails++;
        $display("FAIL R6 done=%0b expected %0b", done, exp_done);
      end
      tests++;
      if (result !== exp_res) begin
        fails++;
        $display("FAIL %s result=%0d expected %0d", exp_done ? tag : "R8", result, exp_res);
      end
      tests++;
      if (fault !== exp_fault) begin
        fails++;
        $display("FAIL %s fault=%0b expected %0b", exp_done ? (exp_fault ? "R4" : "R5") : "R8",
                 fault, exp_fault);
      end
    end
  end

  task automatic req(input string t, input logic [15:0] per, ln, rc, dn, input bit poke);
    @(negedge clk);
    tag = t;
    ref_period = per; line_cnt = ln; ref_cnt = rc; denom = dn; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk);
      ref_period = 16'($urandom); line_cnt = 16'($urandom); ref_cnt = 16'($urandom);
      denom = 16'($urandom); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (left > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tests++;
    if (done !== 1'b0 || result !== 32'd0 || fault !== 1'b0) begin
      fails++;
      $display("FAIL R9 done=%0b result=%0d fault=%0b expected 0 0 0", done, result, fault);
    end
    rst_n = 1'b1;
    req("R1", 16'd100, 16'd3, 16'd50, 16'd88, 1'b0);
    req("R2", 16'd1, 16'd1, 16'd19, 16'd10, 1'b0);
    req("R2", 16'hFFFF, 16'hFFFF, 16'hFFFE, 16'hFFFF, 1'b0);
    req("R3", 16'hFFFF, 16'd1, 16'hFFFF, 16'd1, 1'b0);
    req("R4", 16'd500, 16'd0, 16'd77, 16'd88, 1'b0);
    req("R4", 16'd500, 16'd9, 16'd77, 16'd0, 1'b0);
    req("R4", 16'd500, 16'd0, 16'd77, 16'd0, 1'b0);
    req("R5", 16'd500, 16'd9, 16'd0, 16'd264, 1'b0);
    req("R10", 16'd10000, 16'd25, 16'd3000, 16'd88, 1'b0);
    req("R10", 16'd10000, 16'd25, 16'd3000, 16'd264, 1'b0);
    req("R7", 16'd4321, 16'd17, 16'd999, 16'd88, 1'b1);
    @(negedge clk);
    tag = "R7";
    ref_period = 16'd1234; line_cnt = 16'd5; ref_cnt = 16'd777; denom = 16'd264;
    start = 1'b1;
    repeat (3 * LAT) @(negedge clk);
    start = 1'b0;
    while (left > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 150; i++) begin
      logic [15:0] dn, ln;
      case ($urandom_range(0, 3))
        0: dn = 16'd88;
        1: dn = 16'd264;
        default: dn = 16'($urandom);
      endcase
      ln = ($urandom_range(0, 15) == 0) ? 16'd0 : 16'($urandom_range(1, 65535));
      req(ln == 0 ? "R4" : "R3", 16'($urandom), ln, 16'($urandom), dn, bit'($urandom_range(0, 1)));
    end
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired expected completion");
    finish_run();
  end
endmodule